// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the memory address of a load or store from the decoded addressing form, the register operands and the immediate. Three forms exist: base plus index register, base plus sign-extended displacement, and base plus a displacement scaled by four. On non-update forms a base field index of zero makes the base read as zero, so the encoding can address an absolute location without depending on register zero.

The address and the byte-ordered store data are combinational, so the access can leave in the same cycle. When the memory side raises the access-complete strobe, the block registers the byte-ordered, zero-extended load result and the base-register update value. It then pulses their write enables for one cycle. No write happens if the access faulted or the encoding is invalid. A mode input selects little-endian or big-endian ordering. Swapping acts only within the access size of 1, 2, 4 or 8 bytes.

Top module: `lsu_ea_unit`

## Requirements
- R1: With form code 0 (indexed), `ea` equals the base value plus `rb_val`, wrapping modulo 2^64.
- R2: On a non-update form whose `ra_idx` is 0, the base term is zero and `ra_val` has no effect on `ea`.
- R3: With form code 1 (displacement), the 16-bit `imm` is sign-extended to 64 bits and added to the base.
- R4: With form code 2 (scaled displacement), the sign-extended `imm` is shifted left by two bits before it is added to the base.
- R5: With `upd` set, `ra_idx` 0 is not replaced by zero. One cycle after a good completion, `base_we` pulses with `base_wdata` equal to the address of that access.
- R6: `bad_form` is 1 for form code 3, for an update form with `ra_idx` 0, and for an update load with `ra_idx` equal to `rt_idx`. A completion then asserts neither write enable.
- R7: A completion with `fault` high asserts neither `ld_we` nor `base_we`.
- R8: `st_data_out` holds the low 2^`size` bytes of `st_data`. They are in the same order when `le_mode` is 1 and reversed when it is 0. All higher bytes are zero. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes.
- R9: One cycle after a good load completion, `ld_we` pulses and `ld_wdata` holds `ld_data` ordered and zero-extended by the same rule as R8.
- R10: Write enables last exactly one cycle per `done` strobe and stay low when `done` is low.
- R11: Under synchronous reset, `ld_we` and `base_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| form | input | 2 | Addressing form: 0 indexed, 1 displacement, 2 scaled, 3 reserved |
| upd | input | 1 | Update form: write address back to base |
| is_load | input | 1 | Access is a load |
| ra_idx | input | 5 | Base register field |
| rt_idx | input | 5 | Load target register field |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| imm | input | 16 | Displacement immediate |
| size | input | 2 | Access size code (bytes = 2^size) |
| le_mode | input | 1 | 1 little-endian, 0 big-endian |
| st_data | input | 64 | Store data from register |
| ld_data | input | 64 | Raw data returned from memory |
| done | input | 1 | Access-complete strobe |
| fault | input | 1 | Access reported a fault |
| ea | output | 64 | Effective address |
| st_data_out | output | 64 | Byte-ordered store data |
| bad_form | output | 1 | Invalid encoding flag |
| ld_we | output | 1 | Load target write enable |
| ld_wdata | output | 64 | Load target write value |
| base_we | output | 1 | Base register write enable |
| base_wdata | output | 64 | Base register update value |

## Verification
An update load finishing cleanly writes both the loaded register and the base register in one cycle. The bench provokes this with a single completion strobe on an update-form displacement load whose target and base fields differ. It then judges that `ld_we` and `base_we` rise together on the following cycle, each carrying its own value: the byte-ordered load data and the summed address. The pair is also completed under a fault and under an invalid encoding, to show that both writes drop together.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;
  typedef enum logic [1:0] {
    FORM_INDEX  = 2'd0,
    FORM_DISP   = 2'd1,
    FORM_SCALED = 2'd2,
    FORM_RSVD   = 2'd3
  } ea_form_e;
endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder
  import lsu_ea_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMM_W = 16,
  parameter int RIDX_W = 5
) (
  input  logic [1:0]        form,
  input  logic              upd,
  input  logic              is_load,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rt_idx,
  input  logic [AW-1:0]     ra_val,
  input  logic [AW-1:0]     rb_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [AW-1:0]     ea,
  output logic              bad_form
);
  localparam int EXT_W = AW - IMM_W;

  logic [AW-1:0] imm_sx;
  logic [AW-1:0] base_term;
  logic [AW-1:0] off_term;
  logic          ra_is_zero;

  assign imm_sx     = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign ra_is_zero = (ra_idx == '0);
  // Zero substitution only for non-update forms.
  assign base_term  = (ra_is_zero && !upd) ? '0 : ra_val;

  always_comb begin
    case (ea_form_e'(form))
      FORM_INDEX:  off_term = rb_val;
      FORM_DISP:   off_term = imm_sx;
      FORM_SCALED: off_term = imm_sx << 2;
      default:     off_term = '0;
    endcase
  end

  assign ea = base_term + off_term;

  assign bad_form = (ea_form_e'(form) == FORM_RSVD)
                  || (upd && ra_is_zero)
                  || (upd && is_load && (ra_idx == rt_idx));
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane #(
  parameter int DW     = 64,
  parameter int SIZE_W = 2
) (
  input  logic [DW-1:0]     din,
  input  logic [SIZE_W-1:0] size,
  input  logic              le,
  output logic [DW-1:0]     dout
);
  localparam int NB = DW / 8;

  always_comb begin
    int nb;
    int src;
    dout = '0;
    nb   = 1 << size;
    for (int i = 0; i < NB; i++) begin
      src = le ? i : (nb - 1 - i);
      if (i < nb) dout[i*8 +: 8] = din[src*8 +: 8];
    end
  end
endmodule

// File: rtl/lsu_wb_ctrl.sv
module lsu_wb_ctrl #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          fault,
  input  logic          bad_form,
  input  logic          is_load,
  input  logic          upd,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] ld_ordered,
  output logic          ld_we,
  output logic [DW-1:0] ld_wdata,
  output logic          base_we,
  output logic [AW-1:0] base_wdata
);
  logic good;
  assign good = done && !fault && !bad_form;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_we      <= 1'b0;
      base_we    <= 1'b0;
      ld_wdata   <= '0;
      base_wdata <= '0;
    end else begin
      ld_we   <= good && is_load;
      base_we <= good && upd;
      if (done) begin
        ld_wdata   <= ld_ordered;
        base_wdata <= ea;
      end
    end
  end

  assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    $past(fault) |-> (!ld_we && !base_we));
  assert_bad_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    $past(bad_form) |-> (!ld_we && !base_we));
  assert_we_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_we || base_we) |-> $past(done));
  assert_base_value_R5: assert property (@(posedge clk) disable iff (rst)
    base_we |-> (base_wdata == $past(ea)));
endmodule

// File: rtl/lsu_ea_unit.sv
module lsu_ea_unit
  import lsu_ea_pkg::*;
#(
  parameter int AW     = 64,
  parameter int DW     = 64,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        form,
  input  logic              upd,
  input  logic              is_load,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rt_idx,
  input  logic [AW-1:0]     ra_val,
  input  logic [AW-1:0]     rb_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SIZE_W-1:0] size,
  input  logic              le_mode,
  input  logic [DW-1:0]     st_data,
  input  logic [DW-1:0]     ld_data,
  input  logic              done,
  input  logic              fault,
  output logic [AW-1:0]     ea,
  output logic [DW-1:0]     st_data_out,
  output logic              bad_form,
  output logic              ld_we,
  output logic [DW-1:0]     ld_wdata,
  output logic              base_we,
  output logic [AW-1:0]     base_wdata
);
  logic [DW-1:0] ld_ordered;

  lsu_ea_adder #(.AW(AW), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_adder (
    .form(form), .upd(upd), .is_load(is_load), .ra_idx(ra_idx),
    .rt_idx(rt_idx), .ra_val(ra_val), .rb_val(rb_val), .imm(imm),
    .ea(ea), .bad_form(bad_form)
  );

  lsu_byte_lane #(.DW(DW), .SIZE_W(SIZE_W)) u_st_lane (
    .din(st_data), .size(size), .le(le_mode), .dout(st_data_out)
  );

  lsu_byte_lane #(.DW(DW), .SIZE_W(SIZE_W)) u_ld_lane (
    .din(ld_data), .size(size), .le(le_mode), .dout(ld_ordered)
  );

  lsu_wb_ctrl #(.AW(AW), .DW(DW)) u_wb (
    .clk(clk), .rst(rst), .done(done), .fault(fault), .bad_form(bad_form),
    .is_load(is_load), .upd(upd), .ea(ea), .ld_ordered(ld_ordered),
    .ld_we(ld_we), .ld_wdata(ld_wdata), .base_we(base_we),
    .base_wdata(base_wdata)
  );

  always_comb begin
    if (!rst && !upd && ra_idx == '0 && ea_form_e'(form) == FORM_INDEX)
      assert_ra_zero_index_R2: assert (ea == rb_val);
  end

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!ld_we && !base_we));
endmodule

// File: tb/lsu_ea_unit_tb.sv
module lsu_ea_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  form;
  logic        upd, is_load, le_mode, done, fault;
  logic [4:0]  ra_idx, rt_idx;
  logic [63:0] ra_val, rb_val, st_data, ld_data;
  logic [15:0] imm;
  logic [1:0]  size;
  logic [63:0] ea, st_data_out, ld_wdata, base_wdata;
  logic        bad_form, ld_we, base_we;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsu_ea_unit u_dut (
    .clk(clk), .rst(rst), .form(form), .upd(upd), .is_load(is_load),
    .ra_idx(ra_idx), .rt_idx(rt_idx), .ra_val(ra_val), .rb_val(rb_val),
    .imm(imm), .size(size), .le_mode(le_mode), .st_data(st_data),
    .ld_data(ld_data), .done(done), .fault(fault), .ea(ea),
    .st_data_out(st_data_out), .bad_form(bad_form), .ld_we(ld_we),
    .ld_wdata(ld_wdata), .base_we(base_we), .base_wdata(base_wdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    form = 2'd0; upd = 0; is_load = 0; le_mode = 1; done = 0; fault = 0;
    ra_idx = 5'd1; rt_idx = 5'd2; ra_val = '0; rb_val = '0; imm = '0;
    size = 2'd3; st_data = '0; ld_data = '0;
  endtask

  task automatic t_reset();
    idle(); rst = 1; done = 1; is_load = 1; upd = 1;
    repeat (3) @(negedge clk);
    chk("R11 ld_we", {63'd0, ld_we}, 64'd0);
    chk("R11 base_we", {63'd0, base_we}, 64'd0);
    idle(); rst = 0;
    @(negedge clk);
  endtask

  task automatic t_indexed();
    form = 2'd0; ra_idx = 5'd3; ra_val = 64'hFFFF_FFFF_FFFF_FFF0; rb_val = 64'h20; #1;
    chk("R1 wrap", ea, 64'h10);
    ra_idx = 5'd0; ra_val = 64'h1234; rb_val = 64'h40; #1;
    chk("R2 index ra0", ea, 64'h40);
    @(negedge clk);
  endtask

  task automatic t_disp();
    form = 2'd1; ra_idx = 5'd7; ra_val = 64'h1000; imm = 16'hFFFC; #1;
    chk("R3 neg disp", ea, 64'hFFC);
    ra_idx = 5'd0; ra_val = 64'h5555; imm = 16'h8000; #1;
    chk("R3 R2 disp ra0", ea, 64'hFFFF_FFFF_FFFF_8000);
    form = 2'd2; ra_idx = 5'd7; ra_val = 64'h1000; imm = 16'hFFFF; #1;
    chk("R4 scaled neg", ea, 64'hFFC);
    ra_idx = 5'd0; imm = 16'h0010; #1;
    chk("R4 R2 scaled ra0", ea, 64'h40);
    @(negedge clk);
  endtask

  task automatic t_update_pair();
    idle(); form = 2'd1; upd = 1; is_load = 1; ra_idx = 5'd4; rt_idx = 5'd5;
    ra_val = 64'h2000; imm = 16'h8; size = 2'd1; le_mode = 1;
    ld_data = 64'hDEAD_BEEF_CAFE_AABB; done = 1;
    #1 chk("R6 valid", {63'd0, bad_form}, 64'd0);
    @(negedge clk);
    chk("R9 ld_we", {63'd0, ld_we}, 64'd1);
    chk("R9 ld_wdata", ld_wdata, 64'hAABB);
    chk("R5 base_we", {63'd0, base_we}, 64'd1);
    chk("R5 base_wdata", base_wdata, 64'h2008);
    done = 0;
    @(negedge clk);
    chk("R10 ld_we drop", {63'd0, ld_we}, 64'd0);
    chk("R10 base_we drop", {63'd0, base_we}, 64'd0);
  endtask

  task automatic t_invalid();
    idle(); form = 2'd1; upd = 1; ra_idx = 5'd0; ra_val = 64'h500; imm = 16'h4; done = 1;
    #1 chk("R5 no subst", ea, 64'h504);
    chk("R6 upd ra0", {63'd0, bad_form}, 64'd1);
    @(negedge clk);
    chk("R6 no base_we", {63'd0, base_we}, 64'd0);
    idle(); form = 2'd1; upd = 1; is_load = 1; ra_idx = 5'd6; rt_idx = 5'd6; done = 1;
    #1 chk("R6 ra eq rt", {63'd0, bad_form}, 64'd1);
    @(negedge clk);
    chk("R6 no writes", {62'd0, ld_we, base_we}, 64'd0);
    idle(); form = 2'd3; is_load = 1; done = 1;
    #1 chk("R6 reserved form", {63'd0, bad_form}, 64'd1);
    @(negedge clk);
    chk("R6 reserved no ld_we", {63'd0, ld_we}, 64'd0);
    idle(); @(negedge clk);
  endtask

  task automatic t_fault();
    idle(); form = 2'd1; upd = 1; is_load = 1; ra_idx = 5'd4; rt_idx = 5'd5;
    done = 1; fault = 1;
    @(negedge clk);
    chk("R7 fault no writes", {62'd0, ld_we, base_we}, 64'd0);
    idle(); @(negedge clk);
    chk("R10 idle quiet", {62'd0, ld_we, base_we}, 64'd0);
  endtask

  task automatic t_store_order();
    idle(); st_data = 64'h1122_3344_5566_7788;
    le_mode = 1; size = 2'd2; #1 chk("R8 le 4B", st_data_out, 64'h5566_7788);
    le_mode = 0; size = 2'd2; #1 chk("R8 be 4B", st_data_out, 64'h8877_6655);
    size = 2'd1; #1 chk("R8 be 2B", st_data_out, 64'h8877);
    size = 2'd0; #1 chk("R8 be 1B", st_data_out, 64'h88);
    size = 2'd3; #1 chk("R8 be 8B", st_data_out, 64'h8877_6655_4433_2211);
    le_mode = 1; #1 chk("R8 le 8B", st_data_out, 64'h1122_3344_5566_7788);
    @(negedge clk);
  endtask

  task automatic t_load_order();
    idle(); is_load = 1; le_mode = 0; size = 2'd2;
    ld_data = 64'hFFFF_FFFF_0102_0304; done = 1;
    @(negedge clk);
    chk("R9 be 4B ld", ld_wdata, 64'h0403_0201);
    chk("R9 ld_we plain", {63'd0, ld_we}, 64'd1);
    chk("R5 no base_we non-upd", {63'd0, base_we}, 64'd0);
    idle(); @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_indexed();
        t_disp();
        t_update_pair();
        t_invalid();
        t_fault();
        t_store_order();
        t_load_order();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule